// File: doc/BRIEF.md
# Universal Shift Register with Bidirectional Ports

This block is an eight-bit storage register whose behaviour each clock is picked by a two-bit mode select. The four modes are hold, shift toward the high end, shift toward the low end, and parallel load. The parallel data pins are shared between input and output. They are modelled as three split signals: a pad input bus, a pad output bus and one drive enable. In load mode the register takes its value from the pad input bus, and the drivers are switched off whatever the output enables say. In every other mode the register contents can be driven onto the pads, but only while both active-low output enables are low.

Two serial inputs feed the two shift directions, one for each. Two serial tap outputs always show the lowest bit (A) and the highest bit (H). They are never switched off, so two or more registers can be chained into a wider word. A synchronous active-low clear zeroes the register on a rising edge and takes priority over every mode. The contents at power-up are undefined until the first clear.

Top module: `usr_shift_reg`

## Requirements
- R1: With `mode_sel` = 2'b00 and `clr_n` high, the register contents after a rising edge equal the contents before it. No state changes except on a rising edge of `clk`.
- R2: With `mode_sel` = 2'b01 and `clr_n` high, a rising edge moves `ser_right_in` into bit 0 (A), and each bit i moves into bit i+1. The old bit W-1 (H) is dropped.
- R3: With `mode_sel` = 2'b10 and `clr_n` high, a rising edge moves `ser_left_in` into bit W-1 (H), and each bit i moves into bit i-1. The old bit 0 is dropped.
- R4: With `mode_sel` = 2'b11 and `clr_n` high, a rising edge copies `pad_in` into the register. Bit i of `pad_in` goes to bit i of the register.
- R5: A rising edge with `clr_n` low sets all bits to zero, whatever the value of `mode_sel`.
- R6: `pad_oe` is high exactly when `oe_a_n` and `oe_b_n` are both low and `mode_sel` is not 2'b11. In load mode `pad_oe` is low whatever the enables are.
- R7: The output enables have no effect on clearing, shifting, holding or loading. Register results are the same for all four enable combinations.
- R8: `pad_out` always carries the current register contents, in every mode and for every enable setting.
- R9: `tap_first` always equals register bit 0, and `tap_last` always equals register bit W-1.
- R10: Two instances can be chained into a 2W-bit register. The lower instance's `tap_last` feeds the upper instance's `ser_right_in`, and the upper instance's `tap_first` feeds the lower instance's `ser_left_in`. Shifts in either direction then act as a single 2W-bit shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| mode_sel | input | 2 | 00 hold, 01 shift toward H, 10 shift toward A, 11 parallel load |
| oe_a_n | input | 1 | First output enable, active low |
| oe_b_n | input | 1 | Second output enable, active low |
| ser_right_in | input | 1 | Serial bit that enters bit A on a shift toward H |
| ser_left_in | input | 1 | Serial bit that enters bit H on a shift toward A |
| pad_in | input | WIDTH | Value seen on the shared data pins |
| pad_out | output | WIDTH | Register contents presented to the pad drivers |
| pad_oe | output | 1 | Pad drive enable; low means high impedance |
| tap_first | output | 1 | Bit A (bit 0), always driven |
| tap_last | output | 1 | Bit H (bit W-1), always driven |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a clear arrives while a shift or a load is selected, and the clear must win. In the second, load mode is selected while both output enables are low, and the pad drivers must still stay off. The bench sweeps every combination of clear, mode, enable pair and serial inputs over two chained instances, with varied pad data. After each edge it compares the 16-bit word, the taps and the drive enable against an arithmetic model. Any cycle where clear and a shift or load collide is judged on the register being all zero, and every load cycle is judged on `pad_oe` being low.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'b00,
        MODE_SHR  = 2'b01,
        MODE_SHL  = 2'b10,
        MODE_LOAD = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] mode_sel,
    input  logic       oe_a_n,
    input  logic       oe_b_n,
    output usr_mode_e  mode,
    output logic       drive_en
);

    always_comb begin
        mode     = usr_mode_e'(mode_sel);
        // pins are inputs during load, so the drivers must be off then
        drive_en = ~oe_a_n & ~oe_b_n & (mode != MODE_LOAD);
    end

endmodule

// File: rtl/usr_bit_next.sv
module usr_bit_next
    import usr_pkg::*;
(
    input  usr_mode_e mode,
    input  logic      clr_n,
    input  logic      cur,
    input  logic      from_lower,
    input  logic      from_upper,
    input  logic      pad,
    output logic      nxt
);

    always_comb begin
        if (!clr_n) begin
            nxt = 1'b0;
        end else begin
            unique case (mode)
                MODE_HOLD: nxt = cur;
                MODE_SHR:  nxt = from_lower;
                MODE_SHL:  nxt = from_upper;
                MODE_LOAD: nxt = pad;
                default:   nxt = cur;
            endcase
        end
    end

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode_sel,
    input  logic             oe_a_n,
    input  logic             oe_b_n,
    input  logic             ser_right_in,
    input  logic             ser_left_in,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic             pad_oe,
    output logic             tap_first,
    output logic             tap_last
);

    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } usr_state_t;

    usr_state_t       state_d;
    usr_state_t       state_q;
    usr_mode_e        mode;
    logic             drive_en;
    logic [WIDTH-1:0] next_bits;

    usr_mode_decode u_decode (
        .mode_sel (mode_sel),
        .oe_a_n   (oe_a_n),
        .oe_b_n   (oe_b_n),
        .mode     (mode),
        .drive_en (drive_en)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic lower_src;
        logic upper_src;
        if (i == 0) begin : g_low_end
            assign lower_src = ser_right_in;
        end else begin : g_low_mid
            assign lower_src = state_q.bits[i-1];
        end
        if (i == TOP) begin : g_high_end
            assign upper_src = ser_left_in;
        end else begin : g_high_mid
            assign upper_src = state_q.bits[i+1];
        end
        usr_bit_next u_cell (
            .mode       (mode),
            .clr_n      (clr_n),
            .cur        (state_q.bits[i]),
            .from_lower (lower_src),
            .from_upper (upper_src),
            .pad        (pad_in[i]),
            .nxt        (next_bits[i])
        );
    end

    always_comb begin
        state_d      = state_q;
        state_d.bits = next_bits;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign pad_out   = state_q.bits;
    assign pad_oe    = drive_en;
    assign tap_first = state_q.bits[0];
    assign tap_last  = state_q.bits[TOP];

    // Checking only: contents are undefined until the first clear.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) armed_q <= 1'b1;
    end

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && mode_sel == 2'b00) |=> $stable(pad_out)); // R1
    AST_SHR_MOVE: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && mode_sel == 2'b01) |=>
        pad_out == {$past(pad_out[WIDTH-2:0]), $past(ser_right_in)}); // R2
    AST_SHL_MOVE: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && mode_sel == 2'b10) |=>
        pad_out == {$past(ser_left_in), $past(pad_out[WIDTH-1:1])}); // R3
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && mode_sel == 2'b11) |=> pad_out == $past(pad_in)); // R4
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> (pad_out == '0)); // R5
    AST_LOAD_HIZ: assert property (@(posedge clk) disable iff (!armed_q)
        (mode_sel == 2'b11) |-> !pad_oe); // R6
    AST_OE_OFF: assert property (@(posedge clk) disable iff (!armed_q)
        (oe_a_n || oe_b_n) |-> !pad_oe); // R6
    AST_TAPS_TRACK: assert property (@(posedge clk) disable iff (!armed_q)
        (tap_first == pad_out[0]) && (tap_last == pad_out[TOP])); // R9

endmodule

// File: tb/tb_usr_shift_reg.sv
module tb_usr_shift_reg;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clr_n;
    logic [1:0]   mode_sel;
    logic         oe_a_n, oe_b_n;
    logic         sr_in, sl_in;
    logic [W-1:0] pad_lo, pad_hi;
    logic [W-1:0] out_lo, out_hi;
    logic         oe_lo, oe_hi;
    logic         first_lo, last_lo, first_hi, last_hi;

    int           n_checks = 0;
    int           n_fail   = 0;
    logic [2*W-1:0] model;

    always #2.5 clk = ~clk;

    usr_shift_reg #(.WIDTH(W)) dut (
        .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_right_in(sr_in), .ser_left_in(first_hi),
        .pad_in(pad_lo), .pad_out(out_lo), .pad_oe(oe_lo),
        .tap_first(first_lo), .tap_last(last_lo)
    );

    usr_shift_reg #(.WIDTH(W)) dut_hi (
        .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel),
        .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
        .ser_right_in(last_lo), .ser_left_in(sl_in),
        .pad_in(pad_hi), .pad_out(out_hi), .pad_oe(oe_hi),
        .tap_first(first_hi), .tap_last(last_hi)
    );

    task automatic check(input string tag, input string what,
                         input logic [2*W-1:0] got, input logic [2*W-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic check_state(input string tag);
        check(tag, "word R8", {out_hi, out_lo}, model);
        check("R9", "taps", {12'h0, first_hi, last_hi, first_lo, last_lo},
              {12'h0, model[W], model[2*W-1], model[0], model[W-1]});
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        clr_n = 1'b0; mode_sel = 2'b01; oe_a_n = 1'b0; oe_b_n = 1'b0;
        sr_in = 1'b1; sl_in = 1'b1; pad_lo = 8'hA5; pad_hi = 8'h3C;
        @(posedge clk);
        @(negedge clk);
        model = '0;
        check_state("R5");   // clear beats shift on the very first edge
        for (int pass = 0; pass < 8; pass++) begin
            for (int combo = 0; combo < 128; combo++) begin
                string tag;
                logic  exp_oe;
                clr_n    = ((combo + pass) % 11) != 3;
                mode_sel = 2'(combo);
                oe_a_n   = combo[2];
                oe_b_n   = combo[3];
                sr_in    = combo[4];
                sl_in    = combo[5] ^ pass[0];
                pad_lo   = 8'(pass * 29 + combo * 7 + 60);
                pad_hi   = 8'((pass * 53) ^ (combo * 11));
                #1;
                exp_oe = !oe_a_n && !oe_b_n && mode_sel != 2'b11;
                check("R6", "pad_oe", {14'h0, oe_hi, oe_lo}, {14'h0, exp_oe, exp_oe});
                @(posedge clk);
                if (!clr_n) begin
                    model = '0; tag = "R5";
                end else begin
                    case (mode_sel)
                        2'b00: tag = "R1";
                        2'b01: begin model = {model[2*W-2:0], sr_in}; tag = "R2 R10"; end
                        2'b10: begin model = {sl_in, model[2*W-1:1]}; tag = "R3 R10"; end
                        default: begin model = {pad_hi, pad_lo}; tag = "R4"; end
                    endcase
                end
                @(negedge clk);
                // enables varied across the sweep: R7 judged on the same word check
                check_state({tag, " R7"});
            end
        end
        // register must not move between edges: R1
        mode_sel = 2'b11; clr_n = 1'b1; pad_lo = ~model[W-1:0]; pad_hi = ~model[2*W-1:W];
        #1;
        check("R1", "no change before edge", {out_hi, out_lo}, model);
        summary();
        $finish;
    end

endmodule